// File: doc/BRIEF.md
# Timer Output-Compare Channel with Forced Compare

This block is one output-compare channel of a 16-bit timer. Each cycle it compares the timer count with a programmed compare value. When the two are equal on a cycle in which the timer actually advances, it raises a sticky interrupt flag and updates a waveform pin. In clear-on-compare mode it also asks the counter to restart, using a one-clock clear request. The pin update is chosen by a 2-bit action code: hold, toggle, drive low or drive high.

A write-only force strobe produces the same pin update as a real match, with no other effect. It never sets the interrupt flag and never asks for a counter clear. The strobe acts only in the non-PWM modes. In the PWM modes it is ignored, and PWM waveform generation is handled elsewhere.

All three outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is asserted (active-low `rstN` = 0), and at the first edge after it, `wavePin`, `irqFlag` and `clrReq` are all 0.
- R2: A real match, meaning `cntEn` = 1 and `cntVal` == `cmpVal` at a clock edge, sets `irqFlag` from the next cycle on. This holds in every mode.
- R3: When `cntEn` = 0, equal values are not a match: the flag, the pin and the clear request are left as they were.
- R4: In non-PWM modes (`modeSel` = 00 normal, 01 clear-on-compare), a match applies `actSel` to the pin at the next cycle: 00 holds, 01 toggles, 10 drives 0, 11 drives 1.
- R5: A match in mode 01 drives `clrReq` high for the next cycle only. In mode 00, `clrReq` stays 0.
- R6: In a non-PWM mode, `forceWr` = 1 applies the action of the `actSel` value sampled in that same cycle, exactly as a match would.
- R7: A force alone never sets `irqFlag`.
- R8: A force alone never raises `clrReq`, including in mode 01.
- R9: In PWM modes (`modeSel[1]` = 1), the force strobe is ignored and matches do not move the pin. Matches still set the flag.
- R10: `irqFlag` stays set until `flagClr` = 1 is sampled. If a match and `flagClr` arrive in the same cycle, the set wins.
- R11: A match and a force in the same cycle apply the action once. For example, a toggle flips the pin a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | 16 | Current timer count |
| cntEn | input | 1 | Timer advances this cycle |
| modeSel | input | 2 | 00 normal, 01 clear-on-compare, 1x PWM |
| actSel | input | 2 | Compare-output action code |
| cmpVal | input | 16 | Compare value |
| forceWr | input | 1 | Force-compare strobe |
| flagClr | input | 1 | Write-one-to-clear for the interrupt flag |
| wavePin | output | 1 | Waveform pin |
| irqFlag | output | 1 | Compare interrupt flag |
| clrReq | output | 1 | One-clock counter clear request |

## Verification
Two pairs of events can fall in the same cycle: a real match together with a force strobe, and a flag-setting match together with a flag clear. The bench provokes both pairs on purpose. It runs a toggle action with force and match coincident, so the correct result is a single flip, not two. It also clears the flag in the very cycle a new match arrives, where the flag must stay set. A long stretch of random stimulus follows, with small count and compare ranges so that these collisions happen often. A behavioural reference model judges every cycle.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  typedef struct packed {
    logic       applyPin;
    logic       setFlag;
    logic       reqClear;
    logic [1:0] actCode;
  } strobe_t;

  function automatic logic nextPin(input logic cur, input logic [1:0] code);
    case (act_e'(code))
      ACT_TOGGLE: nextPin = ~cur;
      ACT_LOW:    nextPin = 1'b0;
      ACT_HIGH:   nextPin = 1'b1;
      default:    nextPin = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocmp_ctrl.sv
module ocmp_ctrl
  import ocmp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [W-1:0] cntVal,
  input  logic         cntEn,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   actSel,
  input  logic [W-1:0] cmpVal,
  input  logic         forceWr,
  output strobe_t      strb
);
  logic hit, pwmMode, ctcMode, forceOk;

  always_comb begin
    hit     = cntEn && (cntVal == cmpVal);
    pwmMode = modeSel[1];
    ctcMode = (modeSel == 2'b01);
    forceOk = forceWr && !pwmMode;
    strb.applyPin = !pwmMode && (hit || forceOk);
    strb.setFlag  = hit;
    strb.reqClear = hit && ctcMode;
    strb.actCode  = actSel;
  end
endmodule

// File: rtl/ocmp_dp.sv
module ocmp_dp
  import ocmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    flagClr,
  output logic    wavePin,
  output logic    irqFlag,
  output logic    clrReq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wavePin <= 1'b0;
      irqFlag <= 1'b0;
      clrReq  <= 1'b0;
    end else begin
      if (strb.applyPin) wavePin <= nextPin(wavePin, strb.actCode);
      if (strb.setFlag)  irqFlag <= 1'b1;
      else if (flagClr)  irqFlag <= 1'b0;
      clrReq <= strb.reqClear;
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> irqFlag);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);
  assert_clear_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqClear |=> clrReq);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cntVal,
  input  logic         cntEn,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   actSel,
  input  logic [W-1:0] cmpVal,
  input  logic         forceWr,
  input  logic         flagClr,
  output logic         wavePin,
  output logic         irqFlag,
  output logic         clrReq
);
  strobe_t strb;

  ocmp_ctrl #(.W(W)) u_ctrl (
    .cntVal(cntVal), .cntEn(cntEn), .modeSel(modeSel), .actSel(actSel),
    .cmpVal(cmpVal), .forceWr(forceWr), .strb(strb)
  );

  ocmp_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flagClr(flagClr),
    .wavePin(wavePin), .irqFlag(irqFlag), .clrReq(clrReq)
  );

  assert_pwm_pin_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> $stable(wavePin));
  assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (forceWr && !irqFlag && !(cntEn && cntVal == cmpVal)) |=> !irqFlag);
  assert_force_no_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (forceWr && !(cntEn && cntVal == cmpVal)) |=> !clrReq);
  assert_no_enable_no_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> !clrReq);
endmodule

// File: tb/ocmp_channel_bench.sv
module ocmp_channel_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic        cntEn = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [1:0]  actSel = 2'b00;
  logic [15:0] cmpVal = 16'h0100;
  logic        forceWr = 1'b0;
  logic        flagClr = 1'b0;
  logic        wavePin, irqFlag, clrReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  bit mPin = 0, mFlag = 0, mClr = 0;

  always #10 clk = ~clk;

  ocmp_channel u_ocmp_channel (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntEn(cntEn), .modeSel(modeSel),
    .actSel(actSel), .cmpVal(cmpVal), .forceWr(forceWr), .flagClr(flagClr),
    .wavePin(wavePin), .irqFlag(irqFlag), .clrReq(clrReq)
  );

  // Behavioural reference: R2..R11
  always @(posedge clk) begin
    bit match, pwm, doAct;
    if (!rstN) begin
      mPin = 0; mFlag = 0; mClr = 0;   // R1
    end else begin
      match = cntEn && (cntVal == cmpVal);
      pwm   = modeSel[1];
      doAct = !pwm && (match || forceWr);
      if (doAct) begin
        if (actSel == 2'd1) mPin = !mPin;
        else if (actSel == 2'd2) mPin = 0;
        else if (actSel == 2'd3) mPin = 1;
      end
      if (match) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mClr = match && (modeSel == 2'b01);
    end
  end

  task automatic check(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check("R4/R6/R9/R11 wavePin", wavePin, mPin);
      check("R2/R7/R10 irqFlag", irqFlag, mFlag);
      check("R5/R8 clrReq", clrReq, mClr);
    end
  end

  task automatic step(input bit en, input logic [15:0] cv, input logic [1:0] md,
                      input logic [1:0] act, input bit frc, input bit clr);
    @(negedge clk);
    cntEn = en; cntVal = cv; modeSel = md; actSel = act; forceWr = frc; flagClr = clr;
  endtask

  task automatic idle(); step(0, 16'h0, modeSel, actSel, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values checked directly
    checks++; if ({wavePin, irqFlag, clrReq} !== 3'b000) begin fails++;
      $display("FAIL R1 reset: actual=%b expected=000", {wavePin, irqFlag, clrReq}); end
    rstN = 1'b1;
    idle();
    // R3: equal value without enable
    step(0, 16'h0100, 2'b01, 2'b01, 0, 0); idle();
    // R4: each action on match, normal mode
    for (int a = 0; a < 4; a++) begin
      step(1, 16'h0100, 2'b00, a[1:0], 0, 0); idle();
      step(1, 16'h0100, 2'b00, a[1:0], 0, 0); idle();
    end
    // R10: clear flag, then set+clear same cycle
    step(0, 16'h0, 2'b00, 2'b00, 0, 1); idle();
    step(1, 16'h0100, 2'b00, 2'b00, 0, 1); idle();
    step(0, 16'h0, 2'b00, 2'b00, 0, 1); idle();
    // R5: clear-on-compare match
    step(1, 16'h0100, 2'b01, 2'b01, 0, 0); idle(); idle();
    step(0, 16'h0, 2'b01, 2'b00, 0, 1); idle();
    // R6/R7/R8: force with each code, both non-PWM modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) begin
        step(0, 16'h0, m[1:0], a[1:0], 1, 0); idle();
      end
    // R9: PWM modes ignore force, match keeps pin, flag set
    step(0, 16'h0, 2'b00, 2'b11, 1, 0); idle();
    step(0, 16'h0, 2'b10, 2'b10, 1, 0); idle();
    step(1, 16'h0100, 2'b11, 2'b01, 0, 0); idle();
    step(0, 16'h0, 2'b11, 2'b00, 0, 1); idle();
    // R11: toggle with match and force together
    step(1, 16'h0100, 2'b00, 2'b01, 1, 0); idle();
    step(1, 16'h0100, 2'b01, 2'b01, 1, 0); idle();
    // random stretch with narrow ranges to force collisions
    cmpVal = 16'h0003;
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), 16'($urandom_range(0, 4)), 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    idle(); idle();
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule